// File: doc/BRIEF.md
# Presence-Detect Configuration EEPROM Slave

This block is a two-wire serial bus target that holds a 256-byte configuration store for a memory module. It watches the open-drain clock and data lines with its own system clock and finds the start and stop conditions. It then decodes a select byte and serves byte writes and random, current-address and sequential reads. The block never drives the data line high. It only asserts a pull-low enable, which the pad logic turns into an open-drain driver.

A separate protection block decides which addresses may be written. It sees the current word address on `cur_addr` and returns `wr_permit`. Accepted writes appear as one-cycle requests on `wr_req`, `wr_addr` and `wr_data`, and the internal store takes its update from those requests.

Top module: `pd_eeprom_slave`

## Requirements
- R1: After reset, and after any STOP, the block ignores clock pulses until it sees a START (SDA falling while SCL is high). A STOP (SDA rising while SCL is high) releases SDA.
- R2: The select byte is taken MSB first. Bits 7:4 must equal the function code 4'b1010, bits 3:1 must equal `strap_id[2:0]`, and bit 0 gives the direction (1 = read). Only a matching byte is acknowledged. After a mismatch the block stays silent, and later bytes write nothing until the next START.
- R3: In a write transfer, the byte after the select byte loads the word address. Each later byte that is permitted is acknowledged. It is also issued as a one-cycle `wr_req` with `wr_addr` set to the current address and `wr_data` set to the byte.
- R4: After each accepted write byte, and after each byte sent in a read, the word address goes up by one and wraps from 0xFF to 0x00.
- R5: A random read (select with write direction, address byte, repeated START, select with read direction) returns the stored byte at that address, MSB first.
- R6: In a sequential read the block sends a further byte each time the master acknowledges. A not-acknowledge from the master ends the read and leaves SDA released.
- R7: A read select sent with no address byte returns the byte at the current address, which is the address just after the last byte accessed.
- R8: A data byte whose address `wr_permit` reports as blocked (0) is not acknowledged and is not written.
- R9: A repeated START in the middle of a byte drops that byte and restarts select reception. A STOP in the middle of a byte discards the partial byte without writing it.
- R10: The pull-low enable only rises in the system cycle after a sampled SCL falling edge. It is asserted only for acknowledge bits and for zero data bits.
- R11: Reset (synchronous, active low) leaves SDA released, the word address at 0x00, no write request, and every byte of the store at 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_id | input | 3 | Hardwired address straps compared with select bits 3:1 |
| wr_permit | input | 1 | Protection decision for `cur_addr` (1 = writable) |
| sda_pull | output | 1 | Pull SDA low when 1; released when 0 |
| cur_addr | output | ADDR_W | Current word address, offered to the protection block |
| wr_req | output | 1 | One-cycle write request to the store |
| wr_addr | output | ADDR_W | Address of the write request |
| wr_data | output | 8 | Data of the write request |

## Verification
The assertions check on every cycle that the pull-low enable rises only after an SCL falling edge. They also check that it is released after START and STOP, that a write request is never issued unless the permit was granted, and that the word address moves past each written byte with wrap-around. Whether data is correct across the serial framing can only be shown by the bench's bus transactions. That covers select matching against the straps, random, current-address and sequential reads, the wrap at 0xFF, and the effect of START or STOP inside a byte.

// File: rtl/pd_eeprom_pkg.sv
// Shared constants and the transfer state type for the presence-detect slave.
package pd_eeprom_pkg;

    localparam int BYTE_W  = 8;
    localparam int BCNT_W  = $clog2(BYTE_W + 2);
    localparam logic [BCNT_W-1:0] BIT_DONE = BCNT_W'(BYTE_W);
    localparam logic [BCNT_W-1:0] ACK_DONE = BCNT_W'(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_SEL,    // shifting in the select byte
        ST_ADDR,   // shifting in the word address
        ST_WDAT,   // shifting in write data
        ST_SACK,   // slave acknowledge slot
        ST_RDAT,   // shifting out read data
        ST_MACK    // master acknowledge slot
    } xfer_t;

endpackage

// File: rtl/pd_line_sense.sv
// Synchronises the raw bus lines to clk and reports clock edges and
// START/STOP conditions as one-cycle pulses.
// Assumes SCL is at most a few percent of the clk rate, so that every bus
// phase lasts several clk cycles.
module pd_line_sense #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic sda_now
);

    logic scl_s, sda_s, scl_q, sda_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic scl_r, sda_r;
            logic scl_d, sda_d;
            if (g == 0) begin : g_first
                assign scl_d = scl_raw;
                assign sda_d = sda_raw;
            end else begin : g_next
                assign scl_d = g_stage[g-1].scl_r;
                assign sda_d = g_stage[g-1].sda_r;
            end
            // one synchroniser flop per line, idle-high after reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_r <= 1'b1;
                    sda_r <= 1'b1;
                end else begin
                    scl_r <= scl_d;
                    sda_r <= sda_d;
                end
            end
        end
    endgenerate

    assign scl_s = g_stage[STAGES-1].scl_r;
    assign sda_s = g_stage[STAGES-1].sda_r;

    // previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
    assign sda_now  = sda_s;

endmodule

// File: rtl/pd_store.sv
// Byte store with one synchronous write port and one combinational read port.
// Assumes the caller issues at most one write per cycle; the contents reset to 0xFF.
module pd_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // erase on reset, otherwise take write requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/pd_eeprom_slave.sv
// Two-wire bus target serving a configuration byte store.
// Decodes the select byte against DEV_ID and the straps, then runs byte
// writes and random, current-address and sequential reads.
// Assumes wr_permit is a combinational function of cur_addr.
module pd_eeprom_slave
    import pd_eeprom_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  DEV_ID      = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_id,
    input  logic              wr_permit,
    output logic              sda_pull,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);

    logic scl_rise, scl_fall, start_ev, stop_ev, sda_s;
    xfer_t             state, after_ack;
    logic [BCNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh, rd_byte;
    logic [ADDR_W-1:0] addr_q, wr_addr_q;
    logic [BYTE_W-1:0] wr_data_q;
    logic              pull_q, mack_ok, wr_req_q;
    logic              sel_hit;

    pd_line_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev), .sda_now(sda_s)
    );

    pd_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_req_q), .waddr(wr_addr_q),
        .wdata(wr_data_q), .raddr(addr_q), .rdata(rd_byte)
    );

    // select byte matches function code and straps
    assign sel_hit = (rx_sh[7:4] == DEV_ID) && (rx_sh[3:1] == strap_id);

    // bus transfer sequencer: shifts bits on SCL rise, acts on SCL fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            addr_q    <= '0;
            pull_q    <= 1'b0;
            mack_ok   <= 1'b0;
            wr_req_q  <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_req_q <= 1'b0;
            if (start_ev) begin
                state   <= ST_SEL;
                bit_cnt <= '0;
                pull_q  <= 1'b0;
            end else if (stop_ev) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                pull_q  <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                    if (state == ST_MACK) mack_ok <= ~sda_s;
                end else if (scl_fall) begin
                    unique case (state)
                        ST_SEL: if (bit_cnt == BIT_DONE) begin
                            if (sel_hit) begin
                                pull_q    <= 1'b1;
                                state     <= ST_SACK;
                                after_ack <= rx_sh[0] ? ST_RDAT : ST_ADDR;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        ST_ADDR: if (bit_cnt == BIT_DONE) begin
                            addr_q    <= rx_sh[ADDR_W-1:0];
                            pull_q    <= 1'b1;
                            state     <= ST_SACK;
                            after_ack <= ST_WDAT;
                        end
                        ST_WDAT: if (bit_cnt == BIT_DONE) begin
                            if (wr_permit) begin
                                wr_req_q  <= 1'b1;
                                wr_addr_q <= addr_q;
                                wr_data_q <= rx_sh;
                                addr_q    <= addr_q + 1'b1;
                            end
                            pull_q    <= wr_permit;
                            state     <= ST_SACK;
                            after_ack <= ST_WDAT;
                        end
                        ST_SACK: if (bit_cnt == ACK_DONE) begin
                            bit_cnt <= '0;
                            state   <= after_ack;
                            if (after_ack == ST_RDAT) begin
                                tx_sh  <= rd_byte;
                                pull_q <= ~rd_byte[BYTE_W-1];
                                addr_q <= addr_q + 1'b1;
                            end else begin
                                pull_q <= 1'b0;
                            end
                        end
                        ST_RDAT: begin
                            if (bit_cnt == BIT_DONE) begin
                                pull_q <= 1'b0;
                                state  <= ST_MACK;
                            end else begin
                                tx_sh  <= tx_sh << 1;
                                pull_q <= ~tx_sh[BYTE_W-2];
                            end
                        end
                        ST_MACK: if (bit_cnt == ACK_DONE) begin
                            bit_cnt <= '0;
                            if (mack_ok) begin
                                tx_sh  <= rd_byte;
                                pull_q <= ~rd_byte[BYTE_W-1];
                                addr_q <= addr_q + 1'b1;
                                state  <= ST_RDAT;
                            end else begin
                                pull_q <= 1'b0;
                                state  <= ST_IDLE;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign sda_pull = pull_q;
    assign cur_addr = addr_q;
    assign wr_req   = wr_req_q;
    assign wr_addr  = wr_addr_q;
    assign wr_data  = wr_data_q;

endmodule

// File: rtl/pd_eeprom_slave_chk.sv
// Property checker bound to the slave; observes ports and sequencer events.
module pd_eeprom_slave_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_fall,
    input logic              start_ev,
    input logic              stop_ev,
    input logic              sda_pull,
    input logic              wr_req,
    input logic              wr_permit,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [ADDR_W-1:0] wr_addr
);

    // R10
    pull_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall));

    // R1
    stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_pull);

    // R9
    start_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_pull);

    // R8
    write_permitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> $past(wr_permit));

    // R4
    addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> cur_addr == ADDR_W'(wr_addr + 1'b1));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);

endmodule

bind pd_eeprom_slave pd_eeprom_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .sda_pull(sda_pull), .wr_req(wr_req),
    .wr_permit(wr_permit), .cur_addr(cur_addr), .wr_addr(wr_addr)
);

// File: tb/sim_pd_eeprom_slave.sv
// Bench: acts as bus master with a tabled write/read-back walk, then directed cases.
module sim_pd_eeprom_slave;

    localparam int Q = 10;                // clk cycles per quarter SCL period
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] SEL_R = {4'b1010, STRAP, 1'b1};

    // {lock, addr, data, expected data ack}
    localparam logic [17:0] VEC [6] = '{
        {1'b0, 8'h00, 8'hA5, 1'b1},
        {1'b0, 8'h7F, 8'h3C, 1'b1},
        {1'b1, 8'h10, 8'h55, 1'b0},
        {1'b1, 8'h80, 8'h96, 1'b1},
        {1'b1, 8'hFF, 8'h01, 1'b1},
        {1'b0, 8'h20, 8'h00, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic lock = 1'b0;
    logic sda_pull, wr_req, wr_permit;
    logic [7:0] cur_addr, wr_addr, wr_data;
    wire  sda_bus = sda_m & ~sda_pull;

    int n_chk = 0, n_err = 0, wr_cnt = 0, rise_bad = 0;
    logic [7:0] last_wa = '0, last_wd = '0;
    logic prev_pull = 1'b0;

    always #10 clk = ~clk;

    assign wr_permit = !(lock && !cur_addr[7]);

    pd_eeprom_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .strap_id(STRAP), .wr_permit(wr_permit), .sda_pull(sda_pull),
        .cur_addr(cur_addr), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // observe write requests and pull-enable rises away from the active edge
    always @(negedge clk) begin
        if (wr_req) begin
            wr_cnt++;
            last_wa = wr_addr;
            last_wd = wr_data;
        end
        if (sda_pull && !prev_pull && scl_m) rise_bad++;
        prev_pull = sda_pull;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic half(); repeat (Q) @(negedge clk); endtask
    task automatic bus_start(); sda_m = 1; half(); scl_m = 1; half(); sda_m = 0; half(); scl_m = 0; half(); endtask
    task automatic bus_stop(); sda_m = 0; half(); scl_m = 1; half(); sda_m = 1; half(); endtask
    task automatic put_bit(input logic b); sda_m = b; half(); scl_m = 1; half(); half(); scl_m = 0; half(); endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1; half(); scl_m = 1; half(); ack = !sda_bus; half(); scl_m = 0; half();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            half(); scl_m = 1; half(); b[i] = sda_bus; half(); scl_m = 0; half();
        end
        sda_m = !mack; half(); scl_m = 1; half(); half(); scl_m = 0; half(); sda_m = 1;
    endtask

    task automatic write_one(input logic [7:0] a, input logic [7:0] d, output logic dack);
        logic k;
        bus_start(); send_byte(SEL_W, k); send_byte(a, k); send_byte(d, dack); bus_stop();
    endtask

    task automatic read_at(input logic [7:0] a, output logic [7:0] d);
        logic k;
        bus_start(); send_byte(SEL_W, k); send_byte(a, k);
        bus_start(); send_byte(SEL_R, k); recv_byte(d, 1'b0); bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int exp_wr;
        exp_wr = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 pull", sda_pull, 0);
        chk("R11 addr", cur_addr, 0);
        chk("R11 wr_req", wr_req, 0);

        // R11 erased contents via current-address read at 0x00; R2 ack of match
        bus_start(); send_byte(SEL_R, ack); chk("R2 select ack", ack, 1);
        recv_byte(d, 1'b0); bus_stop();
        chk("R11 erased byte", d, 8'hFF);

        // table walk: R3 write, R8 protection, R5 random read-back
        for (int v = 0; v < 6; v++) begin
            lock = VEC[v][17];
            write_one(VEC[v][16:9], VEC[v][8:1], ack);
            chk("R3/R8 data ack", ack, VEC[v][0]);
            if (VEC[v][0]) begin
                exp_wr++;
                chk("R3 wr_addr", last_wa, VEC[v][16:9]);
                chk("R3 wr_data", last_wd, VEC[v][8:1]);
            end
            chk("R8 write count", wr_cnt, exp_wr);
            read_at(VEC[v][16:9], d);
            chk("R5 read back", d, VEC[v][0] ? VEC[v][8:1] : 8'hFF);
        end
        lock = 0;

        // R1: clocking without START is ignored
        send_byte(SEL_W, ack); chk("R1 no start no ack", ack, 0);
        bus_stop(); chk("R1 released", sda_pull, 0);

        // R2: strap mismatch and wrong function code
        bus_start(); send_byte({4'b1010, 3'b100, 1'b0}, ack); chk("R2 strap nack", ack, 0);
        send_byte(8'h40, ack); send_byte(8'h77, ack); bus_stop();
        chk("R2 no write", wr_cnt, exp_wr);
        read_at(8'h40, d); chk("R2 untouched", d, 8'hFF);
        bus_start(); send_byte({4'b0110, STRAP, 1'b0}, ack); chk("R2 code nack", ack, 0);
        bus_stop();

        // R4: sequential write across the top of the space
        bus_start(); send_byte(SEL_W, ack); send_byte(8'hFE, ack);
        for (int i = 1; i <= 4; i++) begin
            send_byte(8'(i * 8'h11), ack); chk("R4 seq ack", ack, 1);
        end
        bus_stop();
        exp_wr += 4;
        chk("R4 wrapped addr", cur_addr, 8'h02);

        // R6: sequential read from 0xFE through the wrap
        bus_start(); send_byte(SEL_W, ack); send_byte(8'hFE, ack);
        bus_start(); send_byte(SEL_R, ack);
        recv_byte(d, 1'b1); chk("R6 byte0", d, 8'h11);
        recv_byte(d, 1'b1); chk("R6 byte1", d, 8'h22);
        recv_byte(d, 1'b0); chk("R6 byte2", d, 8'h33);
        chk("R6 released after nack", sda_pull, 0);
        bus_stop();

        // R7: current-address read continues at 0x01
        bus_start(); send_byte(SEL_R, ack); recv_byte(d, 1'b0); bus_stop();
        chk("R7 current byte", d, 8'h44);
        chk("R7 addr", cur_addr, 8'h02);

        // R9: repeated START inside a data byte
        bus_start(); send_byte(SEL_W, ack); send_byte(8'h30, ack);
        for (int i = 0; i < 5; i++) put_bit(i[0]);
        bus_start(); send_byte(SEL_R, ack); chk("R9 restart ack", ack, 1);
        recv_byte(d, 1'b0); bus_stop();
        chk("R9 restart data", d, 8'hFF);
        chk("R9 restart no write", wr_cnt, exp_wr);

        // R9: STOP inside a data byte
        bus_start(); send_byte(SEL_W, ack); send_byte(8'h31, ack);
        for (int i = 0; i < 7; i++) put_bit(i[0]);
        bus_stop();
        chk("R9 stop no write", wr_cnt, exp_wr);
        read_at(8'h31, d); chk("R9 stop data", d, 8'hFF);

        // R10: pull enable never rose while SCL was high
        chk("R10 pull timing", rise_bad, 0);
        summary();
    end

endmodule